// File: doc/BRIEF.md
# Downspread Clock Modulation Controller

This block produces the frequency-modulation word for a programmable clock divider. When spreading is selected, the synthesized clock is swept below its nominal frequency and never above it, which lowers the spectral peaks that the clock radiates. The output is a signed offset that is never positive. It follows a symmetric triangle: it falls from zero to the programmed depth and then climbs back to zero. The same offset word is meant to drive every divider that must stay in step, such as the processor clock path and the bus clock path, and optionally the interrupt controller clock path.

The profile advances one step on each update tick. The half-period of the triangle is a power of two, `2**span_log2` steps. The modulation rate is therefore the tick rate divided by `2**(span_log2+1)`. For example, a tick near 2.1 MHz with `span_log2 = 5` gives a rate of about 32 kHz, which lies inside the usual 30 to 33 kHz window. Depth is programmed in units of 0.01 % from 0 to 60, which is at most 0.6 % below nominal. Each depth unit is worth `SCALE` LSBs of divider offset.

Spreading is selected by driving `spread_n` low. When the select goes high in the middle of a sweep, the offset does not jump. It returns to zero at the normal step rate and then stays there.

Top module: `downspread_mod`

## Requirements
- R1: A synchronous active-high `rst` clears the triangle phase and forces `offset` to 0. After `rst` is released, the first enabled tick starts a new profile from phase 0.
- R2: While `spread_n` is high and the phase is zero, ticks leave `offset` at 0 whatever the depth.
- R3: With `spread_n` low, each tick moves the phase by exactly one step. The phase rises 0,1,...,P and then falls back to 0, where P = 2**k and k is the effective span. One full period is 2P ticks.
- R4: At phase p, `offset` equals -((D * SCALE * p) >> k), where D is the effective depth. The result is -(D * SCALE) at the peak p = P.
- R5: `offset` is never positive. Its magnitude never exceeds 60 * SCALE.
- R6: A `depth` value above 60 acts as 60.
- R7: `depth` and `span_log2` are captured only while the phase is zero. A change made during a sweep takes effect in the next period.
- R8: If `spread_n` goes high while the phase is non-zero, the phase reverses if it was rising. It then steps down by one per tick to zero and stays there.
- R9: `offset` is registered. A tick sampled at clock edge n moves the phase at that edge, and `offset` shows the new value after edge n+1. Between ticks, `offset` holds its value.
- R10: A `span_log2` of 0 acts as 1. A value above `MAX_SPAN` (default 10) acts as `MAX_SPAN`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle pulse that advances the profile by one step |
| spread_n | input | 1 | Spread select, active low (high gives nominal frequency) |
| depth | input | DEPTH_W (7) | Spread depth in 0.01 % units, saturated at 60 |
| span_log2 | input | SPAN_W (4) | log2 of the triangle half-period in ticks |
| offset | output | OFS_W (9) | Signed divider offset, zero or negative |

## Verification
The hardest states to reach from the ports are a sweep that is interrupted partway up its ramp and a sweep whose configuration is rewritten before it returns to zero. The stimulus reaches them by counting ticks exactly from a known zero phase. It then changes `spread_n`, or `depth` and `span_log2`, at a chosen phase and follows every later step against a triangle computed arithmetically. The clamp of the span to its maximum requires a sweep of more than two thousand ticks. That sweep is run in full so that both the mid-point and the peak are observed.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_t;

    // Saturate an integer into [lo, hi]
    function automatic int sat_int(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/dsm_cfg_hold.sv
module dsm_cfg_hold #(
    parameter int DEPTH_W   = 7,
    parameter int MAX_DEPTH = 60,
    parameter int SPAN_W    = 4,
    parameter int MAX_SPAN  = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               at_zero,
    input  logic [DEPTH_W-1:0] depth_in,
    input  logic [SPAN_W-1:0]  span_in,
    output logic [DEPTH_W-1:0] depth_q,
    output logic [SPAN_W-1:0]  span_q
);
    import dsm_pkg::*;

    logic [DEPTH_W-1:0] depth_sat;
    logic [SPAN_W-1:0]  span_sat;

    always_comb begin
        depth_sat = DEPTH_W'(sat_int(int'(depth_in), 0, MAX_DEPTH));
        span_sat  = SPAN_W'(sat_int(int'(span_in), 1, MAX_SPAN));
    end

    // Settings only move while the profile rests at zero offset
    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q <= '0;
            span_q  <= SPAN_W'(1);
        end else if (at_zero) begin
            depth_q <= depth_sat;
            span_q  <= span_sat;
        end
    end

endmodule

// File: rtl/dsm_triangle.sv
module dsm_triangle #(
    parameter int SPAN_W   = 4,
    parameter int MAX_SPAN = 10,
    localparam int PHASE_W = MAX_SPAN + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               spread_n,
    input  logic [SPAN_W-1:0]  span_q,
    output logic [PHASE_W-1:0] phase,
    output logic               at_zero
);
    import dsm_pkg::*;

    typedef struct packed {
        logic [PHASE_W-1:0] ph;
        dir_t               dir;
    } tri_state_t;

    tri_state_t st_q, st_d;
    logic [PHASE_W-1:0] peak;
    logic [PHASE_W-1:0] ph_inc;
    logic [PHASE_W-1:0] ph_dec;

    always_comb begin
        peak   = PHASE_W'(1) << span_q;
        ph_inc = st_q.ph + PHASE_W'(1);
        ph_dec = st_q.ph - PHASE_W'(1);
        st_d   = st_q;
        if (tick) begin
            if (st_q.ph == '0) begin
                st_d.dir = DIR_UP;
                if (!spread_n) st_d.ph = PHASE_W'(1);
            end else if (st_q.dir == DIR_UP) begin
                if (spread_n) begin
                    // spreading withdrawn: turn around, same step rate
                    st_d.dir = DIR_DOWN;
                    st_d.ph  = ph_dec;
                end else begin
                    st_d.ph = ph_inc;
                    if (ph_inc == peak) st_d.dir = DIR_DOWN;
                end
            end else begin
                st_d.ph = ph_dec;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ph  <= '0;
            st_q.dir <= DIR_UP;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase   = st_q.ph;
    assign at_zero = (st_q.ph == '0);

endmodule

// File: rtl/dsm_scale.sv
module dsm_scale #(
    parameter int DEPTH_W  = 7,
    parameter int SCALE    = 4,
    parameter int SPAN_W   = 4,
    parameter int PHASE_W  = 11,
    parameter int MAG_W    = 8,
    localparam int OFS_W   = MAG_W + 1,
    localparam int SCALE_W = $clog2(SCALE + 1),
    localparam int PROD_W  = DEPTH_W + SCALE_W + PHASE_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [DEPTH_W-1:0]      depth_q,
    input  logic [SPAN_W-1:0]       span_q,
    input  logic [PHASE_W-1:0]      phase,
    output logic signed [OFS_W-1:0] offset
);
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] shifted;
    logic [MAG_W-1:0]  mag;
    logic [OFS_W-1:0]  neg;

    always_comb begin
        prod    = PROD_W'(depth_q) * PROD_W'(SCALE) * PROD_W'(phase);
        shifted = prod >> span_q;
        mag     = shifted[MAG_W-1:0];
        neg     = OFS_W'(0) - {1'b0, mag};
    end

    always_ff @(posedge clk) begin
        if (rst) offset <= '0;
        else     offset <= neg;
    end

endmodule

// File: rtl/downspread_mod.sv
module downspread_mod #(
    parameter int DEPTH_W   = 7,
    parameter int MAX_DEPTH = 60,
    parameter int SCALE     = 4,
    parameter int SPAN_W    = 4,
    parameter int MAX_SPAN  = 10,
    localparam int PHASE_W  = MAX_SPAN + 1,
    localparam int MAG_W    = $clog2(MAX_DEPTH * SCALE + 1),
    localparam int OFS_W    = MAG_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic                    spread_n,
    input  logic [DEPTH_W-1:0]      depth,
    input  logic [SPAN_W-1:0]       span_log2,
    output logic signed [OFS_W-1:0] offset
);
    logic [DEPTH_W-1:0] depth_q;
    logic [SPAN_W-1:0]  span_q;
    logic [PHASE_W-1:0] phase;
    logic               at_zero;

    dsm_cfg_hold #(
        .DEPTH_W(DEPTH_W), .MAX_DEPTH(MAX_DEPTH),
        .SPAN_W(SPAN_W), .MAX_SPAN(MAX_SPAN)
    ) u_cfg (
        .clk(clk), .rst(rst), .at_zero(at_zero),
        .depth_in(depth), .span_in(span_log2),
        .depth_q(depth_q), .span_q(span_q)
    );

    dsm_triangle #(
        .SPAN_W(SPAN_W), .MAX_SPAN(MAX_SPAN)
    ) u_tri (
        .clk(clk), .rst(rst), .tick(tick), .spread_n(spread_n),
        .span_q(span_q), .phase(phase), .at_zero(at_zero)
    );

    dsm_scale #(
        .DEPTH_W(DEPTH_W), .SCALE(SCALE), .SPAN_W(SPAN_W),
        .PHASE_W(PHASE_W), .MAG_W(MAG_W)
    ) u_scale (
        .clk(clk), .rst(rst), .depth_q(depth_q), .span_q(span_q),
        .phase(phase), .offset(offset)
    );

endmodule

// File: rtl/dsm_checker.sv
module dsm_checker #(
    parameter int OFS_W   = 9,
    parameter int MAX_MAG = 240
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    tick,
    input logic signed [OFS_W-1:0] offset
);
    logic [OFS_W-1:0] mag;
    assign mag = OFS_W'(0) - offset;

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (offset == '0));

    // R5
    never_above_nominal_chk: assert property (@(posedge clk) disable iff (rst)
        !offset[OFS_W-1] |-> (offset == '0));

    // R5
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        offset[OFS_W-1] |-> (mag <= OFS_W'(MAX_MAG)));

    // R9
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(tick, 2) && !$past(rst)) |-> $stable(offset));

endmodule

bind downspread_mod dsm_checker #(
    .OFS_W(OFS_W), .MAX_MAG(MAX_DEPTH * SCALE)
) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .offset(offset)
);

// File: tb/downspread_mod_test.sv
module downspread_mod_test;
    localparam int SCALE = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       spread_n = 1'b1;
    logic [6:0] depth = '0;
    logic [3:0] span_log2 = 4'd1;
    logic signed [8:0] offset;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    downspread_mod uut (
        .clk(clk), .rst(rst), .tick(tick), .spread_n(spread_n),
        .depth(depth), .span_log2(span_log2), .offset(offset)
    );

    always #10 clk = ~clk;

    function automatic int exp_off(input int d, input int k, input int p);
        int dc = (d > 60) ? 60 : d;
        int kc = (k < 1) ? 1 : ((k > 10) ? 10 : k);
        return -((dc * SCALE * p) >> kc);
    endfunction

    function automatic int tri_ph(input int n, input int k);
        int pk = 1 << k;
        int m = n % (2 * pk);
        return (m <= pk) ? m : 2 * pk - m;
    endfunction

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: offset %0d expected %0d", tag, act, expv);
        end
    endtask

    // called at a falling edge; returns two falling edges later
    task automatic step();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic cfg(input int d, input int k);
        depth = 7'(d);
        span_log2 = 4'(k);
        @(negedge clk);
    endtask

    initial begin
        automatic int dl[6] = '{0, 1, 37, 60, 61, 127};
        int v;
        repeat (3) @(negedge clk);
        chk("R1", int'(offset), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", int'(offset), 0);

        // R2: disabled at rest, ticks have no effect
        cfg(60, 2);
        for (int i = 0; i < 10; i++) begin
            step();
            chk("R2", int'(offset), 0);
        end

        // R9: latency and hold; k=1, depth 60
        spread_n = 1'b0;
        cfg(60, 1);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk("R9", int'(offset), 0);
        @(negedge clk);
        chk("R9", int'(offset), -120);
        repeat (3) @(negedge clk);
        chk("R9", int'(offset), -120);
        step(); chk("R4", int'(offset), -240);
        step(); chk("R3", int'(offset), -120);
        step(); chk("R3", int'(offset), 0);

        // R3 R4 R6 R5 sweeps
        for (int k = 1; k <= 3; k++) begin
            for (int j = 0; j < 6; j++) begin
                cfg(dl[j], k);
                for (int n = 1; n <= 4 * (1 << k); n++) begin
                    step();
                    v = int'(offset);
                    if (dl[j] > 60)
                        chk("R6", v, exp_off(dl[j], k, tri_ph(n, k)));
                    else if (tri_ph(n, k) == (1 << k))
                        chk("R4", v, exp_off(dl[j], k, tri_ph(n, k)));
                    else
                        chk("R3", v, exp_off(dl[j], k, tri_ph(n, k)));
                    checks++;
                    if (v > 0) begin
                        fails++;
                        $display("FAIL R5: offset %0d expected <= 0", v);
                    end
                end
            end
        end

        // R7: settings changed mid-sweep apply next period
        cfg(20, 2);
        step(); step();
        chk("R7", int'(offset), exp_off(20, 2, 2));
        depth = 7'd50;
        span_log2 = 4'd3;
        for (int n = 3; n <= 8; n++) begin
            step();
            chk("R7", int'(offset), exp_off(20, 2, tri_ph(n, 2)));
        end
        for (int n = 1; n <= 16; n++) begin
            step();
            chk("R7", int'(offset), exp_off(50, 3, tri_ph(n, 3)));
        end

        // R8: withdraw spread while rising at phase 5 (k=3)
        cfg(60, 3);
        for (int n = 1; n <= 5; n++) step();
        chk("R8", int'(offset), exp_off(60, 3, 5));
        spread_n = 1'b1;
        for (int p = 4; p >= 0; p--) begin
            step();
            chk("R8", int'(offset), exp_off(60, 3, p));
        end
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R8", int'(offset), 0);
        end

        // R10: span 0 acts as 1
        spread_n = 1'b0;
        cfg(60, 0);
        for (int n = 1; n <= 4; n++) begin
            step();
            chk("R10", int'(offset), exp_off(60, 1, tri_ph(n, 1)));
        end
        // R10: span 15 acts as 10
        cfg(60, 15);
        for (int n = 1; n <= 2048; n++) begin
            step();
            if (n == 1 || n == 512 || n == 1024 || n == 1536 || n == 2048)
                chk("R10", int'(offset), exp_off(60, 10, tri_ph(n, 10)));
        end

        // R1: reset mid-sweep, then a fresh start
        cfg(40, 2);
        step(); step(); step();
        chk("R1", int'(offset), exp_off(40, 2, 3));
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", int'(offset), 0);
        cfg(40, 2);
        step();
        chk("R1", int'(offset), exp_off(40, 2, 1));

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule